// File: doc/BRIEF.md
# Read-Triggered Atomic Sequence Counter

This block keeps one shared 32-bit sequence number that several processor cores use to put debug events in a global order. A core claims the next number by reading one register window. That read adds one to the counter and returns the value it produced, so no two readers ever receive the same number. A second register window shows the current value without changing it. Software can also write to that second window to preset the counter.

The bus fabric arbitrates between the cores, so the block sees at most one access per clock cycle. One access is one transaction on a simple single-beat port. The request line rises, may stay high for any number of cycles, and then falls. The block also watches the timer enable level. A low-to-high change of that level clears the sequence number.

Top module: `atomic_read_counter`

## Requirements
- R1: After reset, the counter is zero and `busRdata` is zero.
- R2: A read transaction at word index 2 (the increment window) adds one to the counter. From the cycle after the first request cycle, `busRdata` holds the new counter value.
- R3: A read transaction at word index 5 (the view window) loads `busRdata` with the counter value and leaves the counter unchanged.
- R4: A transaction starts only in a cycle where `busReq` is high after a cycle where it was low. Holding `busReq` high for more cycles never causes a second increment or a second write.
- R5: A write transaction at word index 5 sets the counter to `busWdata`, and later reads start from that value.
- R6: The counter is 32 bits wide. An increment from all ones gives zero, and the read returns zero.
- R7: A rising edge of `timerEnable` (low in one cycle, high in the next) clears the counter to zero. Holding `timerEnable` at a steady level has no effect.
- R8: If an enable rising edge falls in the same cycle as the start of an increment read, the clear wins: the counter becomes zero and the read returns zero. A clear also beats a view-window write that starts in the same cycle.
- R9: A write to the increment window, or an access to any index other than 2 or 5, leaves the counter unchanged. Reads of those other indices return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busReq | input | 1 | Request line, high for the length of one transaction |
| busWrite | input | 1 | 1 = write transaction, 0 = read transaction |
| busAddr | input | 3 | Word index of the access |
| busWdata | input | 32 | Write data |
| timerEnable | input | 1 | Timer enable level; its rising edge clears the counter |
| busRdata | output | 32 | Read data, captured at the start of each read transaction |

## Verification
The bench holds requests for one to four cycles. A design that detects the level of `busReq` instead of its rising edge would add one per held cycle, so the returned numbers would skip ahead. Presetting the counter to all ones checks the wrap: a design that saturates returns all ones again instead of zero. The bench raises the enable in the same cycle as an increment read and as a preset write. A design with the wrong priority returns one, or keeps the written value, instead of zero. Sweeping every word index, with reads and writes, catches a decode that lets a write to the increment window, or a stray index, alter the counter.

// File: rtl/arc_pkg.sv
package arc_pkg;
  // One-cycle strobes from the control to the datapath.
  typedef struct packed {
    logic clear;    // enable rising edge: zero the counter
    logic load;     // preset the counter from write data
    logic bump;     // add one to the counter
    logic capNext;  // read data <= counter + 1
    logic capCur;   // read data <= counter
    logic capZero;  // read data <= 0
  } arcStrobe_t;
endpackage

// File: rtl/arc_ctrl.sv
module arc_ctrl
  import arc_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int INC_IDX  = 2,
  parameter int VIEW_IDX = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              timerEnable,
  output arcStrobe_t        strb
);
  localparam logic [ADDR_W-1:0] IncAddr  = ADDR_W'(INC_IDX);
  localparam logic [ADDR_W-1:0] ViewAddr = ADDR_W'(VIEW_IDX);

  logic reqPrev;
  logic enPrev;
  logic start;
  logic enRise;
  logic hitInc;
  logic hitView;
  logic rdStart;
  logic wrStart;

  // Previous-cycle levels for edge detection. The enable resets high, so
  // a timer that is already enabled after reset does not look like an edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqPrev <= 1'b0;
      enPrev  <= 1'b1;
    end else begin
      reqPrev <= busReq;
      enPrev  <= timerEnable;
    end
  end

  always_comb begin
    start   = busReq & ~reqPrev;
    enRise  = timerEnable & ~enPrev;
    hitInc  = (busAddr == IncAddr);
    hitView = (busAddr == ViewAddr);
    rdStart = start & ~busWrite;
    wrStart = start & busWrite;

    // Counter update priority: clear, then preset, then increment.
    strb.clear   = enRise;
    strb.load    = wrStart & hitView & ~enRise;
    strb.bump    = rdStart & hitInc & ~enRise;
    // Read data capture. An increment read that meets a clear returns zero.
    strb.capNext = rdStart & hitInc & ~enRise;
    strb.capCur  = rdStart & hitView;
    strb.capZero = rdStart & ~hitView & (~hitInc | enRise);
  end
endmodule

// File: rtl/arc_datapath.sv
module arc_datapath
  import arc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  arcStrobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] countVal,
  output logic [DATA_W-1:0] rdData
);
  localparam logic [DATA_W-1:0] One = DATA_W'(1);

  logic [DATA_W-1:0] countQ;
  logic [DATA_W-1:0] countInc;
  logic [DATA_W-1:0] rdQ;

  // Natural wrap from all ones to zero.
  assign countInc = countQ + One;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (strb.clear) begin
      countQ <= '0;
    end else if (strb.load) begin
      countQ <= wrData;
    end else if (strb.bump) begin
      countQ <= countInc;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdQ <= '0;
    end else if (strb.capNext) begin
      rdQ <= countInc;
    end else if (strb.capCur) begin
      rdQ <= countQ;
    end else if (strb.capZero) begin
      rdQ <= '0;
    end
  end

  assign countVal = countQ;
  assign rdData   = rdQ;
endmodule

// File: rtl/atomic_read_counter.sv
module atomic_read_counter
  import arc_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 3,
  parameter int INC_IDX  = 2,
  parameter int VIEW_IDX = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              timerEnable,
  output logic [DATA_W-1:0] busRdata
);
  arcStrobe_t        strb;
  logic [DATA_W-1:0] countVal;

  arc_ctrl #(
    .ADDR_W  (ADDR_W),
    .INC_IDX (INC_IDX),
    .VIEW_IDX(VIEW_IDX)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busReq     (busReq),
    .busWrite   (busWrite),
    .busAddr    (busAddr),
    .timerEnable(timerEnable),
    .strb       (strb)
  );

  arc_datapath #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (busWdata),
    .countVal(countVal),
    .rdData  (busRdata)
  );
endmodule

// File: rtl/arc_checker.sv
module arc_checker #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 3,
  parameter int INC_IDX  = 2,
  parameter int VIEW_IDX = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              busReq,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              timerEnable,
  input logic [DATA_W-1:0] busRdata,
  input logic [DATA_W-1:0] countVal
);
  logic chkReqPrev;
  logic chkEnPrev;
  logic begins;
  logic rise;
  logic atInc;
  logic atView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chkReqPrev <= 1'b0;
      chkEnPrev  <= 1'b1;
    end else begin
      chkReqPrev <= busReq;
      chkEnPrev  <= timerEnable;
    end
  end

  assign begins = busReq && !chkReqPrev;
  assign rise   = timerEnable && !chkEnPrev;
  assign atInc  = (busAddr == ADDR_W'(INC_IDX));
  assign atView = (busAddr == ADDR_W'(VIEW_IDX));

  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    begins && !busWrite && atInc && !rise |=> countVal == $past(countVal) + 1); // R2
  AST_INC_RETURN: assert property (@(posedge clk) disable iff (!rstN)
    begins && !busWrite && atInc && !rise |=> busRdata == countVal); // R2
  AST_VIEW_PURE: assert property (@(posedge clk) disable iff (!rstN)
    begins && !busWrite && atView && !rise |=> $stable(countVal) && busRdata == $past(countVal)); // R3
  AST_ONE_PER_TXN: assert property (@(posedge clk) disable iff (!rstN)
    busReq && chkReqPrev && !rise |=> $stable(countVal)); // R4
  AST_PRESET: assert property (@(posedge clk) disable iff (!rstN)
    begins && busWrite && atView && !rise |=> countVal == $past(busWdata)); // R5
  AST_EDGE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    rise |=> countVal == '0); // R7
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    rise && begins && !busWrite && atInc |=> busRdata == '0); // R8
  AST_INC_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    begins && busWrite && !atView && !rise |=> $stable(countVal)); // R9
endmodule

bind atomic_read_counter arc_checker #(
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W),
  .INC_IDX (INC_IDX),
  .VIEW_IDX(VIEW_IDX)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busReq     (busReq),
  .busWrite   (busWrite),
  .busAddr    (busAddr),
  .busWdata   (busWdata),
  .timerEnable(timerEnable),
  .busRdata   (busRdata),
  .countVal   (countVal)
);

// File: tb/atomic_read_counter_tb.sv
module atomic_read_counter_tb;
  localparam int DW = 32;
  localparam logic [2:0] INC  = 3'd2;
  localparam logic [2:0] VIEW = 3'd5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busReq = 1'b0;
  logic          busWrite = 1'b0;
  logic [2:0]    busAddr = '0;
  logic [DW-1:0] busWdata = '0;
  logic          timerEnable = 1'b1;
  logic [DW-1:0] busRdata;

  int checks = 0;
  int fails = 0;
  logic [DW-1:0] model = '0;

  always #10 clk = ~clk;  // 50 MHz

  atomic_read_counter u_dut (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .timerEnable(timerEnable),
    .busRdata(busRdata)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One transaction held for 'hold' cycles; optional enable rise at its start.
  task automatic txn(input logic wr, input logic [2:0] a, input logic [DW-1:0] d,
                     input int hold, input logic riseEn);
    @(negedge clk);
    busReq = 1'b1; busWrite = wr; busAddr = a; busWdata = d;
    if (riseEn) timerEnable = 1'b1;
    repeat (hold) @(negedge clk);
    busReq = 1'b0; busWrite = 1'b0;
  endtask

  task automatic viewCheck(input string tag);
    txn(1'b0, VIEW, '0, 1, 1'b0);
    check(tag, busRdata, model);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 rdata after reset", busRdata, '0);
    viewCheck("R1 counter after reset");

    // R2/R4: increment reads with hold lengths 1..4
    for (int i = 0; i < 24; i++) begin
      txn(1'b0, INC, '0, (i % 4) + 1, 1'b0);
      model = model + 1;
      check("R2 R4 increment read value", busRdata, model);
    end
    viewCheck("R3 view after increments");
    viewCheck("R3 view again unchanged");

    // R5: presets with walking ones, then increment from them
    for (int b = 0; b < DW; b += 3) begin
      model = DW'(1) << b;
      txn(1'b1, VIEW, model, (b % 3) + 1, 1'b0);
      viewCheck("R5 preset value");
      txn(1'b0, INC, '0, 2, 1'b0);
      model = model + 1;
      check("R5 increment after preset", busRdata, model);
    end

    // R6: wrap
    model = 32'hFFFF_FFFE;
    txn(1'b1, VIEW, model, 1, 1'b0);
    txn(1'b0, INC, '0, 1, 1'b0);
    check("R6 reach all ones", busRdata, 32'hFFFF_FFFF);
    txn(1'b0, INC, '0, 3, 1'b0);
    model = '0;
    check("R6 wrap to zero", busRdata, '0);
    viewCheck("R6 counter zero after wrap");

    // R9: sweep every index with writes and reads
    model = 32'h0000_1234;
    txn(1'b1, VIEW, model, 1, 1'b0);
    for (int a = 0; a < 8; a++) begin
      if (a != int'(VIEW)) begin
        txn(1'b1, 3'(a), 32'hDEAD_BEEF, 1, 1'b0);
        viewCheck("R9 write elsewhere ignored");
      end
      if (a != int'(VIEW) && a != int'(INC)) begin
        txn(1'b0, 3'(a), '0, 2, 1'b0);
        check("R9 other index reads zero", busRdata, '0);
        viewCheck("R9 other read leaves counter");
      end
    end

    // R7: steady enable levels have no effect; a rising edge clears
    @(negedge clk); timerEnable = 1'b0;
    repeat (3) @(negedge clk);
    viewCheck("R7 enable low keeps counter");
    @(negedge clk); timerEnable = 1'b1;
    model = '0;
    viewCheck("R7 enable rise clears");
    model = 32'h0000_0077;
    txn(1'b1, VIEW, model, 1, 1'b0);
    repeat (4) @(negedge clk);
    viewCheck("R7 enable high keeps counter");

    // R8: clear beats an increment read and a preset write
    @(negedge clk); timerEnable = 1'b0;
    txn(1'b0, INC, '0, 2, 1'b1);
    model = '0;
    check("R8 clear wins over increment read", busRdata, '0);
    viewCheck("R8 counter zero after collision");
    txn(1'b0, INC, '0, 1, 1'b0);
    model = 1;
    check("R8 increment after collision", busRdata, model);
    @(negedge clk); timerEnable = 1'b0;
    txn(1'b1, VIEW, 32'hCAFE_0001, 1, 1'b1);
    model = '0;
    viewCheck("R8 clear wins over preset write");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule